// File: doc/BRIEF.md
# Vector length setup unit

This unit carries out the set-vector-length operation of a simple vector extension. It receives the decoded fields of one instruction: a 7-bit immediate length, a destination register number, the three mode flags `vf`, `vs` and `ms`, and a length value read from a source register. From these it updates a packed vector state word that holds the maximum vector length (MVL) and the current vector length (VL). It can return the new VL to the destination register and it copies `vf` into one bit of a machine status word.

The flag combination `vf`=1, `vs`=0, `ms`=0 turns the same operation into a step request. In that case no length is computed. The unit sends a one-cycle pulse to the external step sequencer and leaves everything else unchanged. All updates from one accepted operation commit on a single clock edge. A completion pulse follows one cycle after that edge. Register file storage, instruction decode and the step sequencer are outside the block.

Top module: `vl_setup_unit`

## Requirements
- R1: While reset is held and after it is released, `state_o`, `status_o`, `wb_en_o`, `step_adv_o` and `done_o` are all zero.
- R2: An accepted operation with `op_vf`=1, `op_vs`=0, `op_ms`=0 raises `step_adv_o` for exactly the cycle after the commit edge. `state_o`, `status_o` and the write-back are left untouched.
- R3: On the setup path with `op_vs`=0, the candidate length is `op_imm`+1, saturated to 127.
- R4: On the setup path with `op_vs`=1, the candidate length is `src_len`, saturated to 127.
- R5: On the setup path with `op_ms`=1, both MVL and VL take the candidate length.
- R6: On the setup path with `op_ms`=0, MVL is unchanged and VL becomes the smaller of the candidate and the current MVL, so VL never exceeds MVL.
- R7: `state_o` is 32 bits. MVL sits in MSB-0 bits 0..6 (`state_o[31:25]`) and VL in MSB-0 bits 7..13 (`state_o[24:18]`). All other bits are zero.
- R8: A setup with a nonzero `op_rd` raises `wb_en_o` for one cycle after the commit edge. In that cycle `wb_addr_o` equals `op_rd` and `wb_data_o` is the new VL zero-extended to 64 bits.
- R9: A setup with `op_rd`=0 does not raise `wb_en_o`.
- R10: A setup sets MSB-0 bit 6 of `status_o` (`status_o[57]`) to `op_vf`. All other status bits remain zero.
- R11: `done_o` is high for exactly the second cycle after every accepted operation, whichever path it took.
- R12: With `op_valid` low, no pulse is produced and no state changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe; the fields below are sampled when it is high |
| op_imm | input | 7 | Immediate length field (length minus one) |
| op_rd | input | 5 | Destination register number; 0 suppresses write-back |
| op_vf | input | 1 | Vertical-first flag |
| op_vs | input | 1 | Take the length from `src_len` |
| op_ms | input | 1 | Set MVL as well as VL |
| src_len | input | 64 | Length value read from a source register |
| state_o | output | 32 | Packed vector state (MVL, VL) |
| status_o | output | 64 | Machine status word holding the vf copy |
| wb_en_o | output | 1 | Destination register write strobe |
| wb_addr_o | output | 5 | Destination register number |
| wb_data_o | output | 64 | Destination register write data |
| step_adv_o | output | 1 | Step advance request pulse |
| done_o | output | 1 | Completion pulse |

## Verification
Each stimulus is applied half a cycle ahead of the edge that commits it. The state word, the status word, the write strobe with its address and data, and the step request are all due in the cycle right after that edge, so the bench samples them at the following falling edge. The completion pulse is due one cycle later and is sampled at the next falling edge, where the bench also confirms that the one-cycle strobes have dropped. Idle cycles with random field values are checked at the same two points to confirm that nothing moves.

// File: rtl/vl_pkg.sv
package vl_pkg;

    typedef enum logic [1:0] {
        OPK_IDLE  = 2'd0,
        OPK_STEP  = 2'd1,
        OPK_SETUP = 2'd2
    } op_kind_e;

    // Index of an MSB-0 bit position inside a word of the given width.
    function automatic int unsigned msb0_to_lsb0(input int unsigned width,
                                                 input int unsigned pos);
        return width - 1 - pos;
    endfunction

endpackage

// File: rtl/vl_op_decode.sv
module vl_op_decode
    import vl_pkg::*;
(
    input  logic     valid_i,
    input  logic     vf_i,
    input  logic     vs_i,
    input  logic     ms_i,
    output op_kind_e kind_o,
    output logic     use_reg_o,
    output logic     set_mvl_o
);

    logic step_combo;

    always_comb begin
        step_combo = vf_i & ~vs_i & ~ms_i;
        kind_o     = OPK_IDLE;
        if (valid_i) begin
            kind_o = step_combo ? OPK_STEP : OPK_SETUP;
        end
        use_reg_o = vs_i;
        set_mvl_o = ms_i;
    end

endmodule

// File: rtl/vl_len_select.sv
module vl_len_select #(
    parameter int unsigned LEN_W = 7,
    parameter int unsigned XLEN  = 64
) (
    input  logic [LEN_W-1:0] imm_i,
    input  logic [XLEN-1:0]  src_i,
    input  logic             use_reg_i,
    output logic [LEN_W-1:0] cand_o
);

    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [LEN_W:0]   imm_plus;
    logic [LEN_W-1:0] imm_len_d;
    logic [LEN_W-1:0] reg_len_d;
    logic             reg_over;

    always_comb begin
        imm_plus  = {1'b0, imm_i} + {{LEN_W{1'b0}}, 1'b1};
        imm_len_d = imm_plus[LEN_W] ? LEN_MAX : imm_plus[LEN_W-1:0];
        reg_over  = |src_i[XLEN-1:LEN_W];
        reg_len_d = reg_over ? LEN_MAX : src_i[LEN_W-1:0];
        cand_o    = use_reg_i ? reg_len_d : imm_len_d;
    end

endmodule

// File: rtl/vl_len_clamp.sv
module vl_len_clamp #(
    parameter int unsigned LEN_W = 7
) (
    input  logic [LEN_W-1:0] cand_i,
    input  logic [LEN_W-1:0] cur_mvl_i,
    input  logic             set_mvl_i,
    output logic [LEN_W-1:0] new_mvl_o,
    output logic [LEN_W-1:0] new_vl_o
);

    always_comb begin
        if (set_mvl_i) begin
            new_mvl_o = cand_i;
            new_vl_o  = cand_i;
        end else begin
            new_mvl_o = cur_mvl_i;
            new_vl_o  = (cand_i > cur_mvl_i) ? cur_mvl_i : cand_i;
        end
    end

endmodule

// File: rtl/vl_setup_unit.sv
module vl_setup_unit
    import vl_pkg::*;
#(
    parameter int unsigned LEN_W      = 7,
    parameter int unsigned XLEN       = 64,
    parameter int unsigned REG_AW     = 5,
    parameter int unsigned STATE_W    = 32,
    parameter int unsigned MVL_POS    = 0,
    parameter int unsigned STATUS_POS = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [LEN_W-1:0]   op_imm,
    input  logic [REG_AW-1:0]  op_rd,
    input  logic               op_vf,
    input  logic               op_vs,
    input  logic               op_ms,
    input  logic [XLEN-1:0]    src_len,
    output logic [STATE_W-1:0] state_o,
    output logic [XLEN-1:0]    status_o,
    output logic               wb_en_o,
    output logic [REG_AW-1:0]  wb_addr_o,
    output logic [XLEN-1:0]    wb_data_o,
    output logic               step_adv_o,
    output logic               done_o
);

    localparam int unsigned VL_POS  = MVL_POS + LEN_W;
    localparam int unsigned MVL_LO  = msb0_to_lsb0(STATE_W, MVL_POS + LEN_W - 1);
    localparam int unsigned VL_LO   = msb0_to_lsb0(STATE_W, VL_POS + LEN_W - 1);
    localparam int unsigned STAT_LO = msb0_to_lsb0(XLEN, STATUS_POS);

    typedef struct packed {
        logic [LEN_W-1:0]  mvl;
        logic [LEN_W-1:0]  vl;
        logic              vf_bit;
        logic              wb_en;
        logic [REG_AW-1:0] wb_addr;
        logic [LEN_W-1:0]  wb_len;
        logic              adv;
        logic              cmt;
        logic              done;
    } regs_t;

    regs_t    r_d, r_q;
    op_kind_e kind;
    logic     use_reg;
    logic     set_mvl;
    logic [LEN_W-1:0] cand;
    logic [LEN_W-1:0] new_mvl;
    logic [LEN_W-1:0] new_vl;

    vl_op_decode u_dec (
        .valid_i   (op_valid),
        .vf_i      (op_vf),
        .vs_i      (op_vs),
        .ms_i      (op_ms),
        .kind_o    (kind),
        .use_reg_o (use_reg),
        .set_mvl_o (set_mvl)
    );

    vl_len_select #(.LEN_W(LEN_W), .XLEN(XLEN)) u_sel (
        .imm_i     (op_imm),
        .src_i     (src_len),
        .use_reg_i (use_reg),
        .cand_o    (cand)
    );

    vl_len_clamp #(.LEN_W(LEN_W)) u_clamp (
        .cand_i    (cand),
        .cur_mvl_i (r_q.mvl),
        .set_mvl_i (set_mvl),
        .new_mvl_o (new_mvl),
        .new_vl_o  (new_vl)
    );

    always_comb begin
        r_d         = r_q;
        r_d.wb_en   = 1'b0;
        r_d.adv     = 1'b0;
        r_d.cmt     = op_valid;
        r_d.done    = r_q.cmt;
        unique case (kind)
            OPK_STEP: begin
                r_d.adv = 1'b1;
            end
            OPK_SETUP: begin
                r_d.mvl     = new_mvl;
                r_d.vl      = new_vl;
                r_d.vf_bit  = op_vf;
                r_d.wb_en   = |op_rd;
                r_d.wb_addr = op_rd;
                r_d.wb_len  = new_vl;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        state_o                         = '0;
        state_o[MVL_LO +: LEN_W]        = r_q.mvl;
        state_o[VL_LO +: LEN_W]         = r_q.vl;
        status_o                        = '0;
        status_o[STAT_LO]               = r_q.vf_bit;
        wb_en_o                         = r_q.wb_en;
        wb_addr_o                       = r_q.wb_addr;
        wb_data_o                       = '0;
        wb_data_o[LEN_W-1:0]            = r_q.wb_len;
        step_adv_o                      = r_q.adv;
        done_o                          = r_q.done;
    end

endmodule

// File: rtl/vl_setup_checks.sv
module vl_setup_checks #(
    parameter int unsigned LEN_W   = 7,
    parameter int unsigned XLEN    = 64,
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned STATE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [STATE_W-1:0] state_o,
    input logic [XLEN-1:0]    status_o,
    input logic               wb_en_o,
    input logic [REG_AW-1:0]  wb_addr_o,
    input logic               step_adv_o,
    input logic               done_o
);

    logic [LEN_W-1:0] mvl_f;
    logic [LEN_W-1:0] vl_f;
    assign mvl_f = state_o[STATE_W-1 -: LEN_W];
    assign vl_f  = state_o[STATE_W-1-LEN_W -: LEN_W];

    a_r2_no_wb_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_adv_o |-> !wb_en_o);

    a_r2_state_kept_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_adv_o |-> ($stable(state_o) && $stable(status_o)));

    a_r6_vl_within_mvl: assert property (@(posedge clk) disable iff (!rst_n)
        vl_f <= mvl_f);

    a_r9_no_wb_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_addr_o != '0));

    a_r11_done_after_op: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ##1 done_o);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!wb_en_o && !step_adv_o && $stable(state_o)));

    a_r7_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_o[STATE_W-1-2*LEN_W:0] == '0);

endmodule

bind vl_setup_unit vl_setup_checks #(
    .LEN_W   (LEN_W),
    .XLEN    (XLEN),
    .REG_AW  (REG_AW),
    .STATE_W (STATE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .state_o    (state_o),
    .status_o   (status_o),
    .wb_en_o    (wb_en_o),
    .wb_addr_o  (wb_addr_o),
    .step_adv_o (step_adv_o),
    .done_o     (done_o)
);

// File: tb/vl_setup_unit_bench.sv
module vl_setup_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [6:0]  op_imm = '0;
    logic [4:0]  op_rd = '0;
    logic        op_vf = 1'b0;
    logic        op_vs = 1'b0;
    logic        op_ms = 1'b0;
    logic [63:0] src_len = '0;
    logic [31:0] state_o;
    logic [63:0] status_o;
    logic        wb_en_o;
    logic [4:0]  wb_addr_o;
    logic [63:0] wb_data_o;
    logic        step_adv_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic finished = 1'b0;

    logic [6:0] m_mvl = '0;
    logic [6:0] m_vl = '0;
    logic       m_vf = 1'b0;

    always #10 clk = ~clk;

    vl_setup_unit u_vl_setup_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_imm(op_imm),
        .op_rd(op_rd), .op_vf(op_vf), .op_vs(op_vs), .op_ms(op_ms),
        .src_len(src_len), .state_o(state_o), .status_o(status_o),
        .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
        .step_adv_o(step_adv_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] cand_len(input logic vs, input logic [6:0] imm,
                                            input logic [63:0] src);
        if (vs) return (src > 64'd127) ? 7'd127 : src[6:0];
        return (imm == 7'd127) ? 7'd127 : imm + 7'd1;
    endfunction

    function automatic logic [31:0] exp_state();
        return {m_mvl, m_vl, 18'd0};
    endfunction

    function automatic logic [63:0] exp_status();
        logic [63:0] s = '0;
        s[57] = m_vf;
        return s;
    endfunction

    task automatic run_op(input logic [6:0] imm, input logic [4:0] rd, input logic vf,
                          input logic vs, input logic ms, input logic [63:0] src);
        logic step;
        logic [6:0] c;
        step = vf & ~vs & ~ms;
        @(negedge clk);
        op_valid = 1'b1; op_imm = imm; op_rd = rd;
        op_vf = vf; op_vs = vs; op_ms = ms; src_len = src;
        if (!step) begin
            c = cand_len(vs, imm, src);
            if (ms) begin m_mvl = c; m_vl = c; end
            else m_vl = (c > m_mvl) ? m_mvl : c;
            m_vf = vf;
        end
        @(negedge clk);
        op_valid = 1'b0;
        op_imm = 7'($urandom); op_rd = 5'($urandom); src_len = {$urandom, $urandom};
        check("R2 step pulse", 64'(step_adv_o), 64'(step));
        check("R7 R5 R6 R3 R4 state", 64'(state_o), 64'(exp_state()));
        check("R10 status", status_o, exp_status());
        check("R8 R9 wb_en", 64'(wb_en_o), 64'(!step && rd != 0));
        if (!step && rd != 0) begin
            check("R8 wb_addr", 64'(wb_addr_o), 64'(rd));
            check("R8 wb_data", wb_data_o, {57'd0, m_vl});
        end
        check("R11 done not early", 64'(done_o), 64'd0);
        @(negedge clk);
        check("R11 done", 64'(done_o), 64'd1);
        check("R2 R8 pulse single", 64'(step_adv_o | wb_en_o), 64'd0);
        check("R12 state held when idle", 64'(state_o), 64'(exp_state()));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                finished = 1'b1;
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 state reset", 64'(state_o), 64'd0);
        check("R1 status reset", status_o, 64'd0);
        check("R1 pulses reset", 64'({wb_en_o, step_adv_o, done_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 64'({state_o, wb_en_o, step_adv_o, done_o}), 64'd0);

        run_op(7'd5, 5'd3, 1'b0, 1'b0, 1'b0, 64'd0);        // R6 clamp to MVL 0
        run_op(7'd9, 5'd4, 1'b0, 1'b0, 1'b1, 64'd0);        // R5 MVL=VL=10
        run_op(7'd20, 5'd7, 1'b0, 1'b0, 1'b0, 64'd0);       // R6 clamp to 10
        run_op(7'd3, 5'd0, 1'b1, 1'b1, 1'b0, 64'd0);        // R4 src 0, R9 rd zero
        run_op(7'd2, 5'd31, 1'b0, 1'b0, 1'b0, 64'd0);       // R3 VL=3
        run_op(7'd0, 5'd9, 1'b1, 1'b0, 1'b0, 64'd55);       // R2 step
        run_op(7'd127, 5'd1, 1'b1, 1'b0, 1'b1, 64'd0);      // R3 saturate 127
        run_op(7'd0, 5'd2, 1'b0, 1'b1, 1'b1, 64'd200);      // R4 saturate 127
        run_op(7'd0, 5'd2, 1'b0, 1'b1, 1'b0, 64'h1_0000_0005); // R4 high bits
        run_op(7'd0, 5'd2, 1'b0, 1'b1, 1'b1, 64'd64);       // R7 field placement

        // R12: idle cycles with random fields change nothing
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            op_vf = 1'($urandom); op_vs = 1'($urandom); op_ms = 1'($urandom);
            op_imm = 7'($urandom); op_rd = 5'($urandom);
            @(negedge clk);
            check("R12 no pulse", 64'({wb_en_o, step_adv_o, done_o}), 64'd0);
            check("R12 state", 64'(state_o), 64'(exp_state()));
            check("R12 status", status_o, exp_status());
        end

        for (int i = 0; i < 300; i++) begin
            logic [63:0] s;
            s = ($urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 140);
            run_op(7'($urandom), (($urandom % 5) == 0) ? 5'd0 : 5'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), s);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule